// File: doc/BRIEF.md
# Serial Equalizer Control Receiver

This block is the digital control front end of a stereo graphic equalizer with fourteen bands, seven per channel. A host drives three slow wires: a serial clock, a serial data line and a strobe. The data bits are shifted into an 8-bit register, least significant bit first, on each rising edge of the serial clock. A rising edge of the strobe executes the byte held in that register as one of two commands.

A band word has its top bit set. It picks the band that later gain words will modify, and it sets the 6 dB or 12 dB range of each channel. A gain word has its top bit clear. It writes a boost, cut or flat level into the band most recently picked. All three wires are synchronised into the system clock. The stored per-band settings are presented in two forms: as raw 5-bit codes, and as decoded thermometer switch enables for the boost and cut resistor taps of every band.

Top module: `eq_ctrl_rx`

## Requirements
- R1: After reset every band holds code 0 (flat), both range flags are 0 (12 dB range) and no band is selected.
- R2: On each rising edge of the synchronised serial clock, the data bit is shifted in. The first bit sent lands in bit 0 of the executed byte, and the eighth bit sent lands in bit 7.
- R3: A byte with bit 7 = 1 is a band word. Bits 3..0 give the band code: codes 1..7 select channel A bands 1..7 (outputs 0..6), codes 8..14 select channel B bands (outputs 7..13), and codes 0 and 15 select no band. Bit 5 = 1 puts channel A in the 6 dB range (`rangeSixDb[0]`), bit 4 = 1 does the same for channel B (`rangeSixDb[1]`), and bit 6 is ignored. A band word updates both range flags every time.
- R4: A byte with bit 7 = 0 is a gain word. Bits 3..0 give the magnitude and bit 4 = 1 means cut. The selected band then stores the 5-bit code {bit4, bits3..0}. Bits 6..5 are ignored.
- R5: A gain word with magnitude 0 stores code 0 (flat), whatever the value of bit 4.
- R6: A gain word with magnitude 13, 14 or 15 leaves every band unchanged.
- R7: A gain word received while no band is selected leaves every band unchanged.
- R8: The band selection persists, so consecutive gain words all apply to the same band. At most one band changes per cycle.
- R9: Commands execute only on a rising strobe edge. Shifting bits without a strobe changes nothing. The strobe does not alter the shift register, so a second strobe with no new bits executes the same byte again.
- R10: For band b and step k (0..11), `boostTap[b*12+k]` is high exactly when band b is not cut and its magnitude is greater than k. `cutTap` follows the same rule for cut settings. The two are never both high.
- R11: The effect of a strobe rising at the pin appears on the outputs after the third rising system clock edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock from the host |
| serData | input | 1 | Serial data, least significant bit first |
| serStrobe | input | 1 | Command execute strobe |
| bandGain | output | 70 | Per-band 5-bit code {cut, magnitude[3:0]}, band 0 in bits 4..0 |
| rangeSixDb | output | 2 | Bit 0 channel A, bit 1 channel B; 1 = 6 dB range |
| boostTap | output | 168 | Per-band boost switch enables, 12 per band |
| cutTap | output | 168 | Per-band cut switch enables, 12 per band |

## Verification
A wrong band selection stays hidden until the next gain word. It then shows up as a change in the wrong 5-bit slice of `bandGain`, and the slice the bench expected to change does not move. Because the bench compares every output against its model on every clock, a shift-order error, a range bit swap or a missed magnitude limit is reported within three clocks of the strobe that exposes it. Selection-loss faults show up on the first gain word after the fault. The directed sequence makes each of these visible by sending gain words to fresh bands, to no band and with out-of-range magnitudes.

// File: rtl/eq_ctrl_pkg.sv
package eq_ctrl_pkg;
  localparam int WORD_W      = 8;
  localparam int CODE_W      = 4;
  localparam int KIND_BIT    = 7;  // 1 = band word, 0 = gain word
  localparam int RANGE_A_BIT = 5;
  localparam int RANGE_B_BIT = 4;
  localparam int DIR_BIT     = 4;  // 1 = cut

  typedef struct packed {
    logic              bandLoad;
    logic              gainLoad;
    logic [WORD_W-1:0] word;
  } eqCmd_t;
endpackage

// File: rtl/eq_sync_chain.sv
module eq_sync_chain #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[STAGES-2:0], d};
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/eq_serial_front.sv
module eq_serial_front
  import eq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   serClk,
  input  logic   serData,
  input  logic   serStrobe,
  output eqCmd_t cmd
);
  logic [2:0]        syncIn;
  logic              sClk, sData, sStb;
  logic              prevClk, prevStb;
  logic              clkRise, stbRise;
  logic [WORD_W-1:0] shiftReg;

  eq_sync_chain #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({serStrobe, serData, serClk}),
    .q   (syncIn)
  );

  assign {sStb, sData, sClk} = syncIn;
  assign clkRise = sClk & ~prevClk;
  assign stbRise = sStb & ~prevStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk  <= 1'b0;
      prevStb  <= 1'b0;
      shiftReg <= '0;
    end else begin
      prevClk <= sClk;
      prevStb <= sStb;
      if (clkRise) shiftReg <= {sData, shiftReg[WORD_W-1:1]};
    end
  end

  always_comb begin
    cmd.word     = shiftReg;
    cmd.bandLoad = stbRise &  shiftReg[KIND_BIT];
    cmd.gainLoad = stbRise & ~shiftReg[KIND_BIT];
  end
endmodule

// File: rtl/eq_band_store.sv
module eq_band_store
  import eq_ctrl_pkg::*;
#(
  parameter int BANDS_PER_CH = 7,
  parameter int MAG_W        = 4,
  parameter int MAX_STEP     = 12
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  eqCmd_t                                 cmd,
  output logic [2*BANDS_PER_CH*(MAG_W+1)-1:0]    bandGain,
  output logic [1:0]                             rangeSixDb,
  output logic [2*BANDS_PER_CH*MAX_STEP-1:0]     boostTap,
  output logic [2*BANDS_PER_CH*MAX_STEP-1:0]     cutTap
);
  localparam int NUM_BANDS = 2 * BANDS_PER_CH;
  localparam int GAIN_W    = MAG_W + 1;
  localparam int SEL_W     = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1;

  logic [CODE_W-1:0] code;
  logic              codeOk;
  logic [MAG_W-1:0]  mag;
  logic              magOk;
  logic [GAIN_W-1:0] newGain;
  logic              selValid;
  logic [SEL_W-1:0]  selIdx;

  assign code    = cmd.word[CODE_W-1:0];
  assign codeOk  = (int'(code) >= 1) && (int'(code) <= NUM_BANDS);
  assign mag     = cmd.word[MAG_W-1:0];
  assign magOk   = int'(mag) <= MAX_STEP;
  assign newGain = (mag == '0) ? '0 : {cmd.word[DIR_BIT], mag};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selValid   <= 1'b0;
      selIdx     <= '0;
      rangeSixDb <= '0;
    end else if (cmd.bandLoad) begin
      selValid   <= codeOk;
      selIdx     <= SEL_W'(code - CODE_W'(1));
      rangeSixDb <= {cmd.word[RANGE_B_BIT], cmd.word[RANGE_A_BIT]};
    end
  end

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    logic              wrEn;
    logic [GAIN_W-1:0] gainQ;

    assign wrEn = cmd.gainLoad & selValid & magOk & (selIdx == SEL_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     gainQ <= '0;
      else if (wrEn) gainQ <= newGain;
    end

    assign bandGain[b*GAIN_W +: GAIN_W] = gainQ;

    for (genvar k = 0; k < MAX_STEP; k++) begin : g_tap
      logic deep;
      assign deep = int'(gainQ[MAG_W-1:0]) > k;
      assign boostTap[b*MAX_STEP+k] = ~gainQ[MAG_W] & deep;
      assign cutTap[b*MAX_STEP+k]   =  gainQ[MAG_W] & deep;
    end
  end
endmodule

// File: rtl/eq_ctrl_rx.sv
module eq_ctrl_rx
  import eq_ctrl_pkg::*;
#(
  parameter int BANDS_PER_CH = 7,
  parameter int MAG_W        = 4,
  parameter int MAX_STEP     = 12,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                serClk,
  input  logic                                serData,
  input  logic                                serStrobe,
  output logic [2*BANDS_PER_CH*(MAG_W+1)-1:0] bandGain,
  output logic [1:0]                          rangeSixDb,
  output logic [2*BANDS_PER_CH*MAX_STEP-1:0]  boostTap,
  output logic [2*BANDS_PER_CH*MAX_STEP-1:0]  cutTap
);
  eqCmd_t cmdBus;

  eq_serial_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rstN     (rstN),
    .serClk   (serClk),
    .serData  (serData),
    .serStrobe(serStrobe),
    .cmd      (cmdBus)
  );

  eq_band_store #(
    .BANDS_PER_CH(BANDS_PER_CH),
    .MAG_W       (MAG_W),
    .MAX_STEP    (MAX_STEP)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmdBus),
    .bandGain  (bandGain),
    .rangeSixDb(rangeSixDb),
    .boostTap  (boostTap),
    .cutTap    (cutTap)
  );
endmodule

// File: rtl/eq_ctrl_rx_chk.sv
module eq_ctrl_rx_chk
  import eq_ctrl_pkg::*;
#(
  parameter int BANDS_PER_CH = 7,
  parameter int MAG_W        = 4,
  parameter int MAX_STEP     = 12
) (
  input logic                                clk,
  input logic                                rstN,
  input eqCmd_t                              cmd,
  input logic [2*BANDS_PER_CH*(MAG_W+1)-1:0] bandGain,
  input logic [1:0]                          rangeSixDb,
  input logic [2*BANDS_PER_CH*MAX_STEP-1:0]  boostTap,
  input logic [2*BANDS_PER_CH*MAX_STEP-1:0]  cutTap
);
  localparam int NUM_BANDS = 2 * BANDS_PER_CH;
  localparam int GAIN_W    = MAG_W + 1;

  logic [NUM_BANDS*GAIN_W-1:0] prevGain;
  logic [NUM_BANDS-1:0]        chg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevGain <= '0;
    else       prevGain <= bandGain;
  end

  always_comb begin
    for (int b = 0; b < NUM_BANDS; b++)
      chg[b] = bandGain[b*GAIN_W +: GAIN_W] != prevGain[b*GAIN_W +: GAIN_W];
  end

  // R1: reset clears all settings
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |-> (bandGain == '0) && (rangeSixDb == '0));

  // R9: no command, no change
  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.bandLoad || cmd.gainLoad) |=> $stable(bandGain) && $stable(rangeSixDb));

  // R3: range flags move only on band words
  p_range_on_band_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.bandLoad |=> $stable(rangeSixDb));

  // R8: at most one band changes per cycle
  p_single_band_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(chg) <= 1);

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_bchk
    // R5: zero magnitude never carries the cut bit
    p_flat_clean_r5: assert property (@(posedge clk) disable iff (!rstN)
      (bandGain[b*GAIN_W +: MAG_W] == '0) |-> !bandGain[b*GAIN_W+MAG_W]);
    // R6: stored magnitude stays within range
    p_mag_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
      int'(bandGain[b*GAIN_W +: MAG_W]) <= MAX_STEP);
    // R10: boost and cut taps never both on
    p_tap_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
      (boostTap[b*MAX_STEP +: MAX_STEP] & cutTap[b*MAX_STEP +: MAX_STEP]) == '0);
  end
endmodule

bind eq_ctrl_rx eq_ctrl_rx_chk #(
  .BANDS_PER_CH(BANDS_PER_CH),
  .MAG_W       (MAG_W),
  .MAX_STEP    (MAX_STEP)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmd       (cmdBus),
  .bandGain  (bandGain),
  .rangeSixDb(rangeSixDb),
  .boostTap  (boostTap),
  .cutTap    (cutTap)
);

// File: tb/test_eq_ctrl_rx.sv
`timescale 1ns/1ps
module test_eq_ctrl_rx;
  localparam int NB   = 14;
  localparam int STEP = 12;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serStrobe = 1'b0;
  logic [NB*5-1:0]    bandGain;
  logic [1:0]         rangeSixDb;
  logic [NB*STEP-1:0] boostTap, cutTap;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eq_ctrl_rx i_eq_ctrl_rx (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serStrobe(serStrobe), .bandGain(bandGain), .rangeSixDb(rangeSixDb),
    .boostTap(boostTap), .cutTap(cutTap)
  );

  // ---------------- behavioural reference model ----------------
  int        mGain[NB];
  int        mRangeA, mRangeB;
  bit        mValid;
  int        mSel;
  logic [7:0] mShift;
  logic [2:0] pipeQ[$];
  logic [2:0] lastS;

  task automatic modelReset();
    foreach (mGain[i]) mGain[i] = 0;
    mRangeA = 0; mRangeB = 0; mValid = 0; mSel = 0; mShift = 8'h00;
    pipeQ.delete(); pipeQ.push_back(3'b000); pipeQ.push_back(3'b000);
    lastS = 3'b000;
  endtask

  task automatic modelExec(logic [7:0] w);
    int c, m;
    if (w[7]) begin
      c = int'(w[3:0]);
      mValid = (c >= 1 && c <= NB);
      mSel = c - 1;
      mRangeA = int'(w[5]);
      mRangeB = int'(w[4]);
    end else begin
      m = int'(w[3:0]);
      if (mValid && m <= STEP) mGain[mSel] = (m == 0) ? 0 : (w[4] ? 16 : 0) + m;
    end
  endtask

  always @(posedge clk) begin
    logic [2:0] cur;
    if (!rstN) modelReset();
    else begin
      cur = pipeQ.pop_front();   // {strobe, data, clock}
      if (cur[2] && !lastS[2]) modelExec(mShift);
      if (cur[0] && !lastS[0]) mShift = {cur[1], mShift[7:1]};
      lastS = cur;
      pipeQ.push_back({serStrobe, serData, serClk});
    end
  end

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R11 and all others: full comparison on every clock
  always @(negedge clk) begin
    logic [NB*5-1:0]    eGain;
    logic [NB*STEP-1:0] eBoost, eCut;
    if (!done) begin
      for (int b = 0; b < NB; b++) begin
        eGain[b*5 +: 5] = 5'(mGain[b]);
        for (int k = 0; k < STEP; k++) begin
          eBoost[b*STEP+k] = (mGain[b] < 16) && ((mGain[b] % 16) > k);
          eCut[b*STEP+k]   = (mGain[b] >= 16) && ((mGain[b] % 16) > k);
        end
      end
      check("R11 per-cycle bandGain", 256'(bandGain), 256'(eGain));
      check("R11 per-cycle rangeSixDb", 256'(rangeSixDb), 256'({2'(mRangeB), 2'(mRangeA)} & 4'b0101 ? {mRangeB[0], mRangeA[0]} : 2'b00));
      check("R10 per-cycle boostTap", 256'(boostTap), 256'(eBoost));
      check("R10 per-cycle cutTap", 256'(cutTap), 256'(eCut));
    end
  end

  // ---------------- stimulus ----------------
  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftByte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      serData = b[i];
      waitClk(HALF);
      serClk = 1'b1;
      waitClk(HALF);
      serClk = 1'b0;
    end
    waitClk(HALF);
  endtask

  task automatic strobe();
    serStrobe = 1'b1;
    waitClk(HALF);
    serStrobe = 1'b0;
    waitClk(HALF + 2);
  endtask

  task automatic sendByte(logic [7:0] b);
    shiftByte(b);
    strobe();
  endtask

  task automatic bandIs(int idx, logic [4:0] exp, string tag);
    check(tag, 256'(bandGain[idx*5 +: 5]), 256'(exp));
  endtask

  task automatic allBandsAre(logic [NB*5-1:0] exp, string tag);
    check(tag, 256'(bandGain), 256'(exp));
  endtask

  initial begin
    logic [NB*5-1:0] snap;
    waitClk(4);
    // R1: reset state
    allBandsAre('0, "R1 reset bands flat");
    check("R1 reset ranges 12dB", 256'(rangeSixDb), 256'(2'b00));
    rstN = 1'b1;
    waitClk(3);
    // R1/R7: gain word before any selection does nothing
    sendByte(8'h05);
    allBandsAre('0, "R1 no band selected after reset");
    // R2/R3/R4: select band 3 (index 2), boost 7
    sendByte(8'h83);
    sendByte(8'h07);
    bandIs(2, 5'h07, "R2 R4 band3 boost7");
    // R8: repeated gain on same band
    sendByte(8'h1A);
    bandIs(2, 5'h1A, "R8 band3 cut10");
    // R4: bits 6..5 ignored
    sendByte(8'h6C);
    bandIs(2, 5'h0C, "R4 ignored bits boost12");
    // R5: cut with magnitude 0 is flat
    sendByte(8'h10);
    bandIs(2, 5'h00, "R5 flat clears cut bit");
    // R6: magnitude over 12 ignored
    sendByte(8'h15);
    bandIs(2, 5'h15, "R6 setup cut5");
    sendByte(8'h0D);
    bandIs(2, 5'h15, "R6 magnitude 13 ignored");
    sendByte(8'h1F);
    bandIs(2, 5'h15, "R6 magnitude 15 ignored");
    // R3: band code 11 with both 6 dB ranges and don't-care bit 6
    sendByte(8'hFB);
    check("R3 both ranges 6dB", 256'(rangeSixDb), 256'(2'b11));
    sendByte(8'h19);
    bandIs(10, 5'h19, "R3 channel B band code 11");
    bandIs(2, 5'h15, "R8 other band untouched");
    // R10: taps for cut 9 on index 10 and cut 5 on index 2
    check("R10 cut taps band 10", 256'(cutTap[10*STEP +: STEP]), 256'(12'h1FF));
    check("R10 boost taps band 10", 256'(boostTap[10*STEP +: STEP]), 256'(12'h000));
    // R7: code 15 selects nothing
    sendByte(8'h8F);
    check("R3 ranges back to 12dB", 256'(rangeSixDb), 256'(2'b00));
    snap = bandGain;
    sendByte(8'h03);
    allBandsAre(snap, "R7 code 15 no band");
    // R3/R7: code 0, channel A 6 dB only
    sendByte(8'hA0);
    check("R3 channel A 6dB only", 256'(rangeSixDb), 256'(2'b01));
    sendByte(8'h04);
    allBandsAre(snap, "R7 code 0 no band");
    // R3: edges of code range
    sendByte(8'h9E);
    check("R3 channel B 6dB only", 256'(rangeSixDb), 256'(2'b10));
    sendByte(8'h01);
    bandIs(13, 5'h01, "R3 band code 14");
    sendByte(8'h81);
    sendByte(8'h1C);
    bandIs(0, 5'h1C, "R3 band code 1 cut12");
    check("R10 cut taps full", 256'(cutTap[0 +: STEP]), 256'(12'hFFF));
    // R9: shifting without strobe changes nothing
    shiftByte(8'h05);
    waitClk(6);
    bandIs(0, 5'h1C, "R9 no strobe no change");
    strobe();
    bandIs(0, 5'h05, "R9 strobe executes shifted word");
    check("R10 boost taps 5", 256'(boostTap[0 +: STEP]), 256'(12'h01F));
    // R9: second strobe reuses the same byte
    sendByte(8'h82);
    strobe();
    sendByte(8'h08);
    bandIs(1, 5'h08, "R9 repeated band strobe keeps selection");
    // R1: mid-run reset
    rstN = 1'b0;
    waitClk(3);
    allBandsAre('0, "R1 mid-run reset");
    rstN = 1'b1;
    waitClk(3);
    sendByte(8'h02);
    allBandsAre('0, "R1 selection cleared by reset");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule